// File: doc/BRIEF.md
# Power-Fail Store/Recall Sequencer

This block orders the nonvolatile operations of an SRAM whose every cell has a nonvolatile shadow. It watches an already synchronized supply-low flag, software requests to save or restore the array, and two indications from the SRAM port: a write strobe and a write-in-flight level. From these it produces a busy lockout, a write-inhibit for the SRAM port, and one-cycle start pulses for the engine that moves data between the array and its shadow. The store, the two restore phases and the grace wait are timed in clock cycles with parameter counts.

A store on power loss runs only if the array has been written since the last save or restore. A write that is still in flight is given a bounded grace window before the save begins, and reads go on during that window. A restore is remembered while the supply is low and runs once the supply comes back. If the supply drops again during a restore, that restore is dropped and stays pending. A restore first clears the array and then loads it. Every count parameter must be at least 1.

Top module: `nv_sequencer`

## Requirements
- R1: While reset is held, busy, store_start, recall_start, rcl_clear and rcl_load are all 0. A restore is pending out of reset. When pwr_low is 0, recall_start pulses in the first cycle after reset is released.
- R2: wr_block is 1 in the same cycle that pwr_low is 1 or busy is 1. A wr_req seen while wr_block is 1 does not count as a write.
- R3: When pwr_low rises with the array written and wr_inflight at 1, busy stays 0 for up to GRACE_CYC cycles. store_start then pulses one cycle after wr_inflight falls, or in cycle GRACE_CYC+1 if wr_inflight stays high.
- R4: When pwr_low rises with the array written and no write in flight, store_start pulses in the next cycle. When pwr_low rises with the array unwritten, no store starts.
- R5: sw_store_req, with pwr_low at 0 and the block idle, starts a store in the next cycle whether or not the array has been written. busy then stays 1 for exactly STORE_CYC cycles.
- R6: sw_store_req is dropped while pwr_low is 1.
- R7: While busy is 1, wr_req, sw_store_req and sw_recall_req have no effect.
- R8: A restore holds rcl_clear for CLEAR_CYC cycles and then rcl_load for LOAD_CYC cycles. busy is 1 throughout.
- R9: A restore becomes pending whenever pwr_low is 1. recall_start pulses in the cycle after pwr_low returns to 0.
- R10: When a store or a restore completes, the written mark is cleared, so a later power loss without a new write starts no store.
- R11: If pwr_low rises during a restore, busy drops in the next cycle and the restore stays pending. It then runs in full after pwr_low falls.
- R12: If sw_store_req and sw_recall_req arrive in the same idle cycle, the store starts and the restore request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_low | input | 1 | Synchronized supply-low flag |
| sw_store_req | input | 1 | Software save request, one-cycle pulse |
| sw_recall_req | input | 1 | Software restore request, one-cycle pulse |
| wr_req | input | 1 | SRAM write strobe, one cycle per write |
| wr_inflight | input | 1 | An SRAM write is still completing |
| busy | output | 1 | Nonvolatile operation running; all SRAM access locked out |
| wr_block | output | 1 | Inhibit new SRAM writes |
| store_start | output | 1 | One-cycle pulse starting a save |
| recall_start | output | 1 | One-cycle pulse starting a restore |
| rcl_clear | output | 1 | Restore is in its clearing phase |
| rcl_load | output | 1 | Restore is in its loading phase |

## Verification
Two events can land in the same clock cycle. The first is a write strobe arriving in the very cycle pwr_low rises. The bench drives both on one edge with the array clean and expects no save. The write must be inhibited by the combinational wr_block and so must not mark the array written. The second is both software requests arriving together. The scoreboard expects one save of STORE_CYC cycles and flags any restore pulse that follows it.

// File: rtl/nv_sequencer.sv
module nv_sequencer #(
  parameter int STORE_CYC = 64,
  parameter int CLEAR_CYC = 8,
  parameter int LOAD_CYC  = 32,
  parameter int GRACE_CYC = 10
)(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_low,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic wr_req,
  input  logic wr_inflight,
  output logic busy,
  output logic wr_block,
  output logic store_start,
  output logic recall_start,
  output logic rcl_clear,
  output logic rcl_load
);
  localparam int M1   = (STORE_CYC > LOAD_CYC) ? STORE_CYC : LOAD_CYC;
  localparam int M2   = (CLEAR_CYC > GRACE_CYC) ? CLEAR_CYC : GRACE_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_GRACE, S_STORE, S_CLEAR, S_LOAD} st_t;

  st_t           st, nst;
  logic [CW-1:0] cnt, ncnt;
  logic          dirty, rcl_pend;
  logic          go_store, go_rcl, done_st, done_rcl;

  assign busy      = (st == S_STORE) || (st == S_CLEAR) || (st == S_LOAD);
  assign wr_block  = pwr_low | busy;
  assign rcl_clear = (st == S_CLEAR);
  assign rcl_load  = (st == S_LOAD);

  always_comb begin
    nst      = st;
    ncnt     = cnt;
    go_store = 1'b0;
    go_rcl   = 1'b0;
    done_st  = 1'b0;
    done_rcl = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (pwr_low) begin
          if (dirty) begin
            if (wr_inflight) begin
              nst  = S_GRACE;
              ncnt = CW'(GRACE_CYC - 1);
            end else begin
              go_store = 1'b1;
            end
          end
        end else if (rcl_pend) begin
          go_rcl = 1'b1;
        end else if (sw_store_req) begin
          go_store = 1'b1;
        end else if (sw_recall_req) begin
          go_rcl = 1'b1;
        end
      end
      S_GRACE: begin
        if (!wr_inflight || cnt == '0) go_store = 1'b1;
        else ncnt = cnt - CW'(1);
      end
      S_STORE: begin
        if (cnt == '0) begin
          nst     = S_IDLE;
          done_st = 1'b1;
        end else begin
          ncnt = cnt - CW'(1);
        end
      end
      S_CLEAR: begin
        if (pwr_low) begin
          nst = S_IDLE;
        end else if (cnt == '0) begin
          nst  = S_LOAD;
          ncnt = CW'(LOAD_CYC - 1);
        end else begin
          ncnt = cnt - CW'(1);
        end
      end
      S_LOAD: begin
        if (pwr_low) begin
          nst = S_IDLE;
        end else if (cnt == '0) begin
          nst      = S_IDLE;
          done_rcl = 1'b1;
        end else begin
          ncnt = cnt - CW'(1);
        end
      end
      default: nst = S_IDLE;
    endcase
    if (go_store) begin
      nst  = S_STORE;
      ncnt = CW'(STORE_CYC - 1);
    end
    if (go_rcl) begin
      nst  = S_CLEAR;
      ncnt = CW'(CLEAR_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      dirty        <= 1'b0;
      rcl_pend     <= 1'b1;
      store_start  <= 1'b0;
      recall_start <= 1'b0;
    end else begin
      st           <= nst;
      cnt          <= ncnt;
      store_start  <= go_store;
      recall_start <= go_rcl;
      if (done_st || done_rcl)        dirty <= 1'b0;
      else if (wr_req && !wr_block)   dirty <= 1'b1;
      if (pwr_low)                    rcl_pend <= 1'b1;
      else if (done_rcl)              rcl_pend <= 1'b0;
    end
  end

  p_write_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_block) |=> dirty);

  p_grace_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GRACE) |-> (!busy && int'(cnt) < GRACE_CYC));

  p_no_store_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && pwr_low && !dirty) |=> !store_start);

  p_store_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STORE && cnt != '0) |=> (busy && !rcl_clear && !rcl_load));

  p_phase_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rcl_load) |-> $past(rcl_clear));

  p_pend_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_low |=> rcl_pend);

  p_clean_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STORE && cnt == '0) |=> !dirty);

  p_abandon_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((rcl_clear || rcl_load) && pwr_low) |=> (!busy && rcl_pend));

  p_one_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_start && recall_start));
endmodule

// File: tb/test_nv_sequencer.sv
module test_nv_sequencer;
  localparam int ST = 20;
  localparam int CL = 5;
  localparam int LD = 12;
  localparam int GR = 6;

  logic clk = 1'b0;
  logic rst_n, pwr_low, sw_store_req, sw_recall_req, wr_req, wr_inflight;
  logic busy, wr_block, store_start, recall_start, rcl_clear, rcl_load;

  always #10 clk = ~clk;

  nv_sequencer #(.STORE_CYC(ST), .CLEAR_CYC(CL), .LOAD_CYC(LD), .GRACE_CYC(GR)) i_nv_sequencer (
    .clk(clk), .rst_n(rst_n), .pwr_low(pwr_low), .sw_store_req(sw_store_req),
    .sw_recall_req(sw_recall_req), .wr_req(wr_req), .wr_inflight(wr_inflight),
    .busy(busy), .wr_block(wr_block), .store_start(store_start),
    .recall_start(recall_start), .rcl_clear(rcl_clear), .rcl_load(rcl_load));

  typedef struct { int kind; int len; } exp_t;
  exp_t sbq[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_op(input int kind, input int len);
    exp_t e;
    e.kind = kind;
    e.len  = len;
    sbq.push_back(e);
  endtask

  task automatic wait_idle();
    while (busy) tick();
    repeat (2) tick();
  endtask

  task automatic wr_pulse();
    wr_req = 1'b1;
    tick();
    wr_req = 1'b0;
  endtask

  task automatic power_back(input string rq);
    expect_op(2, CL + LD);
    pwr_low = 1'b0;
    tick();
    chk(recall_start == 1'b1, rq, recall_start, 1);
    wait_idle();
  endtask

  // monitor: kind 1 = store, kind 2 = restore; len = cycles busy stays high
  initial begin : mon
    exp_t cur;
    int run;
    bit act;
    run = 0;
    act = 1'b0;
    cur.kind = 0;
    cur.len = 0;
    forever begin
      @(negedge clk);
      if (act) begin
        if (busy) run++;
        else begin
          act = 1'b0;
          chk(run == cur.len, (cur.kind == 1) ? "R5 store length" : "R8 restore length", run, cur.len);
        end
      end
      if (rst_n === 1'b1 && (store_start || recall_start)) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R7 unexpected start", store_start ? 1 : 2, 0);
        end else begin
          cur = sbq.pop_front();
          chk((store_start ? 1 : 2) == cur.kind, "R12 start kind", store_start ? 1 : 2, cur.kind);
          act = 1'b1;
          run = 1;
        end
      end
    end
  end

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : drv
    rst_n = 1'b0; pwr_low = 1'b0; sw_store_req = 1'b0; sw_recall_req = 1'b0;
    wr_req = 1'b0; wr_inflight = 1'b0;
    repeat (3) tick();
    chk(!busy && !store_start && !recall_start && !rcl_clear && !rcl_load, "R1 reset outputs", busy, 0);
    expect_op(2, CL + LD);
    rst_n = 1'b1;
    tick();
    chk(recall_start == 1'b1, "R1 power-up restore", recall_start, 1);
    wait_idle();

    // clean array, power loss: no store; store request while low dropped
    pwr_low = 1'b1;
    #1 chk(wr_block == 1'b1, "R2 block on low", wr_block, 1);
    repeat (GR + 4) tick();
    chk(busy == 1'b0, "R4 clean no store", busy, 0);
    sw_store_req = 1'b1;
    tick();
    sw_store_req = 1'b0;
    repeat (ST / 2) tick();
    chk(busy == 1'b0, "R6 store request while low", busy, 0);
    power_back("R9 restore after low");

    // software store regardless; requests during busy ignored; store clears mark
    wr_pulse();
    expect_op(1, ST);
    sw_store_req = 1'b1;
    tick();
    sw_store_req = 1'b0;
    chk(store_start && busy, "R5 store start", store_start, 1);
    tick();
    wr_req = 1'b1; sw_recall_req = 1'b1; sw_store_req = 1'b1;
    tick();
    wr_req = 1'b0; sw_recall_req = 1'b0; sw_store_req = 1'b0;
    chk(wr_block == 1'b1, "R7 block while busy", wr_block, 1);
    wait_idle();
    pwr_low = 1'b1;
    repeat (GR + 4) tick();
    chk(busy == 1'b0, "R10 store clears mark", busy, 0);
    power_back("R9 restore after low");

    // written array, no write in flight: immediate store
    wr_pulse();
    expect_op(1, ST);
    pwr_low = 1'b1;
    tick();
    chk(store_start == 1'b1, "R4 store on low", store_start, 1);
    wait_idle();
    repeat (4) tick();
    chk(busy == 1'b0, "R10 single store", busy, 0);
    power_back("R9 restore after low");

    // grace ends early when write finishes
    wr_pulse();
    wr_inflight = 1'b1;
    pwr_low = 1'b1;
    expect_op(1, ST);
    tick();
    chk(!busy && !store_start, "R3 reads open in grace", busy, 0);
    tick();
    tick();
    wr_inflight = 1'b0;
    tick();
    chk(store_start == 1'b1, "R3 store after write ends", store_start, 1);
    wait_idle();
    power_back("R9 restore after low");

    // grace expires
    wr_pulse();
    wr_inflight = 1'b1;
    pwr_low = 1'b1;
    expect_op(1, ST);
    for (int i = 1; i <= GR; i++) begin
      tick();
      chk(!busy && !store_start, "R3 grace window", busy, 0);
    end
    tick();
    chk(store_start == 1'b1, "R3 grace timeout", store_start, 1);
    wr_inflight = 1'b0;
    wait_idle();
    power_back("R9 restore after low");

    // software restore phases
    begin
      int nc, nl;
      expect_op(2, CL + LD);
      sw_recall_req = 1'b1;
      tick();
      sw_recall_req = 1'b0;
      chk(recall_start && rcl_clear, "R8 restore start", recall_start, 1);
      nc = 0;
      while (rcl_clear) begin nc++; tick(); end
      chk(nc == CL, "R8 clear phase", nc, CL);
      nl = 0;
      while (rcl_load) begin nl++; tick(); end
      chk(nl == LD, "R8 load phase", nl, LD);
      wait_idle();
    end

    // restore clears the written mark
    wr_pulse();
    expect_op(2, CL + LD);
    sw_recall_req = 1'b1;
    tick();
    sw_recall_req = 1'b0;
    wait_idle();
    pwr_low = 1'b1;
    repeat (GR + 4) tick();
    chk(busy == 1'b0, "R10 restore clears mark", busy, 0);
    power_back("R9 restore after low");

    // restore abandoned on supply drop
    expect_op(2, CL + 3);
    sw_recall_req = 1'b1;
    tick();
    sw_recall_req = 1'b0;
    repeat (CL + 2) tick();
    pwr_low = 1'b1;
    tick();
    chk(!busy && !rcl_load, "R11 abandon", busy, 0);
    repeat (5) tick();
    power_back("R11 rerun after abandon");

    // both software requests together
    expect_op(1, ST);
    sw_store_req = 1'b1; sw_recall_req = 1'b1;
    tick();
    sw_store_req = 1'b0; sw_recall_req = 1'b0;
    chk(store_start && !recall_start, "R12 store wins", store_start, 1);
    wait_idle();

    // write strobe in the same cycle as supply drop
    wr_req = 1'b1;
    pwr_low = 1'b1;
    #1 chk(wr_block == 1'b1, "R2 same-cycle block", wr_block, 1);
    tick();
    wr_req = 1'b0;
    repeat (GR + 4) tick();
    chk(busy == 1'b0, "R2 blocked write not counted", busy, 0);
    power_back("R9 restore after low");

    repeat (5) tick();
    chk(sbq.size() == 0, "R5 R9 scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule